// File: doc/BRIEF.md
# Cell Protection Sequencing Controller

This block is the digital sequencing logic of a single-cell lithium protection monitor. It takes comparator results that are already digital: cell above the overvoltage level, cell below the charge-resume level, cell below the undervoltage level, overcurrent and short circuit. It also takes a sleep request. Each fault, and the sleep request, must last for its own qualification delay before it acts. The delay is counted in ticks of a slow timebase. The block then drives two active-low FET enables, keeps sticky fault flags, and moves between an active mode and a sleep mode. While asleep it enables a current-limited recovery charge path.

The two voltage faults are handled differently. An overvoltage opens only the charge FET, and the block stays in the `OV_LOCK` state until the cell falls below the lower charge-resume level. An undervoltage opens both FETs and moves the block to `SLEEP`. Overcurrent and short circuit open only the discharge FET, and each stays latched until software clears its flag after the condition has gone. Software reads the flags and sets the charge-enable and discharge-enable control bits through a small register port.

The mode machine has three states. `ACTIVE` goes to `SLEEP` on a qualified undervoltage or a qualified sleep request, and goes to `OV_LOCK` on a qualified overvoltage. `OV_LOCK` goes to `SLEEP` on the same sleep causes, and goes back to `ACTIVE` when the charge-resume comparator is set. `SLEEP` goes to `ACTIVE` once the sleep request is low and the undervoltage comparator is clear. On that wake transition the discharge-enable bit is forced to 1.

Top module: `cellguard_ctrl`

## Requirements
- R1: After reset the block is in active mode. Both FET enables are low (FETs on) and the recovery output is low. The status register (address 0) reads 0. The control register (address 1) reads 3: discharge-enable in bit 0 and charge-enable in bit 1 are both 1.
- R2: An overvoltage held for OV_DLY ticks sets `chg_fet_n` high and sets status bit 0. The discharge enable is not affected.
- R3: Once an overvoltage has tripped, charging stays off after the overvoltage comparator clears. It turns back on only when the charge-resume comparator is set.
- R4: A condition that drops before its delay completes causes no trip, and the count starts again from zero when the condition next appears.
- R5: An undervoltage held for UV_DLY ticks sets both FET enables high, sets status bit 1, and enters sleep. Status bit 4 reads 1 while asleep.
- R6: `recov_en` is high exactly while the block is in sleep mode.
- R7: When discharge-enable is 0, `dsg_fet_n` is high with no fault present. When charge-enable is 0, `chg_fet_n` is high. When set to 1, either bit allows its FET unless a protection condition overrides it.
- R8: Sleep is left when `sleep_req` is low and the undervoltage comparator is clear, and on that transition discharge-enable is set to 1.
- R9: An overcurrent held for OC_DLY ticks sets `dsg_fet_n` high and sets status bit 2. A short circuit held for SC_DLY ticks does the same and sets status bit 3. SC_DLY is smaller than OC_DLY, and no trip happens without ticks.
- R10: Overcurrent and short-circuit flags, and the discharge cut they cause, stay set until a 1 is written to their status bit while the condition is absent. A write while the condition is present leaves them set.
- R11: Status bits 0 to 3 are write-1-to-clear: writing 0 leaves a flag set.
- R12: A sleep request held for SLP_DLY ticks enters sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow timebase strobe, one cycle wide |
| ov_cmp | input | 1 | Cell above overvoltage level |
| chg_ok_cmp | input | 1 | Cell below charge-resume level |
| uv_cmp | input | 1 | Cell below undervoltage level |
| oc_cmp | input | 1 | Overcurrent detected |
| sc_cmp | input | 1 | Short circuit detected |
| sleep_req | input | 1 | Request to enter sleep |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = control |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 5 | Read data for `reg_addr`, combinational |
| chg_fet_n | output | 1 | Charge FET enable, low = on |
| dsg_fet_n | output | 1 | Discharge FET enable, low = on |
| recov_en | output | 1 | Recovery charge path enable |

## Verification
The assertions check rules that hold on every cycle:
- both FETs are off in sleep;
- a cleared discharge-enable bit always cuts discharge;
- a qualified undervoltage in the active state always leads to sleep;
- the `OV_LOCK` state holds while the resume comparator is clear;
- a latched overcurrent survives while its condition stays;
- discharge-enable is 1 after every wake;
- the delay counters stay in range and return to zero when their condition drops.

Only the directed scenarios can show the exact trip tick counts, the restart of a count after an interrupted condition, the asymmetric recovery of the two voltage faults, and the write-1-to-clear behaviour seen through the register port.

// File: rtl/cellguard_pkg.sv
package cellguard_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_OV_LOCK = 2'd1,
        ST_SLEEP   = 2'd2
    } mode_t;

    localparam int NUM_COND = 5;
    localparam int C_OV  = 0;
    localparam int C_UV  = 1;
    localparam int C_OC  = 2;
    localparam int C_SC  = 3;
    localparam int C_SLP = 4;

    localparam int WR_W = 4;
    localparam int RD_W = 5;

    localparam int ST_B_OV    = 0;
    localparam int ST_B_UV    = 1;
    localparam int ST_B_OC    = 2;
    localparam int ST_B_SC    = 3;
    localparam int ST_B_SLEEP = 4;
    localparam int CT_B_DE    = 0;
    localparam int CT_B_CE    = 1;

    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/cg_qual_timer.sv
module cg_qual_timer #(
    parameter int LIMIT = 4,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cond,
    output logic qual
);
    localparam logic [CW-1:0] TERM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick && (cnt != TERM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = cond && (cnt == TERM);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TERM); // R4
    AST_RESTART_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0)); // R4
endmodule

// File: rtl/cg_regs.sv
module cg_regs
    import cellguard_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [WR_W-1:0]     reg_wdata,
    input  logic [NUM_COND-1:0] qual,
    input  logic                oc_raw,
    input  logic                sc_raw,
    input  logic                wake_pulse,
    input  logic                in_sleep,
    output logic                ov_f,
    output logic                uv_f,
    output logic                oc_f,
    output logic                sc_f,
    output logic                de_bit,
    output logic                ce_bit,
    output logic [RD_W-1:0]     reg_rdata
);
    logic stat_wr;
    logic ctrl_wr;

    assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);
    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_f <= 1'b0;
            uv_f <= 1'b0;
            oc_f <= 1'b0;
            sc_f <= 1'b0;
        end else begin
            if (qual[C_OV])                          ov_f <= 1'b1;
            else if (stat_wr && reg_wdata[ST_B_OV])  ov_f <= 1'b0;
            if (qual[C_UV])                          uv_f <= 1'b1;
            else if (stat_wr && reg_wdata[ST_B_UV])  uv_f <= 1'b0;
            if (qual[C_OC])                                    oc_f <= 1'b1;
            else if (stat_wr && reg_wdata[ST_B_OC] && !oc_raw) oc_f <= 1'b0;
            if (qual[C_SC])                                    sc_f <= 1'b1;
            else if (stat_wr && reg_wdata[ST_B_SC] && !sc_raw) sc_f <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            de_bit <= 1'b1;
            ce_bit <= 1'b1;
        end else begin
            if (wake_pulse)   de_bit <= 1'b1;
            else if (ctrl_wr) de_bit <= reg_wdata[CT_B_DE];
            if (ctrl_wr)      ce_bit <= reg_wdata[CT_B_CE];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_STAT) begin
            reg_rdata[ST_B_OV]    = ov_f;
            reg_rdata[ST_B_UV]    = uv_f;
            reg_rdata[ST_B_OC]    = oc_f;
            reg_rdata[ST_B_SC]    = sc_f;
            reg_rdata[ST_B_SLEEP] = in_sleep;
        end else begin
            reg_rdata[CT_B_DE] = de_bit;
            reg_rdata[CT_B_CE] = ce_bit;
        end
    end

    AST_DE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> de_bit); // R8
    AST_OC_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_f && oc_raw) |=> oc_f); // R10
endmodule

// File: rtl/cg_mode_fsm.sv
module cg_mode_fsm
    import cellguard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_q,
    input  logic uv_q,
    input  logic slp_q,
    input  logic chg_ok,
    input  logic uv_raw,
    input  logic sleep_req,
    input  logic de_bit,
    input  logic ce_bit,
    input  logic oc_f,
    input  logic sc_f,
    output logic chg_fet_n,
    output logic dsg_fet_n,
    output logic recov_en,
    output logic in_sleep,
    output logic wake_pulse
);
    mode_t state;
    mode_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ACTIVE: begin
                if (uv_q || slp_q) nxt = ST_SLEEP;
                else if (ov_q)     nxt = ST_OV_LOCK;
            end
            ST_OV_LOCK: begin
                if (uv_q || slp_q) nxt = ST_SLEEP;
                else if (chg_ok)   nxt = ST_ACTIVE;
            end
            ST_SLEEP: begin
                if (!sleep_req && !uv_raw) nxt = ST_ACTIVE;
            end
            default: nxt = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ACTIVE;
        else        state <= nxt;
    end

    always_comb begin
        in_sleep   = (state == ST_SLEEP);
        recov_en   = (state == ST_SLEEP);
        wake_pulse = (state == ST_SLEEP) && (nxt == ST_ACTIVE);
        chg_fet_n  = !((state == ST_ACTIVE) && ce_bit);
        dsg_fet_n  = !((state != ST_SLEEP) && de_bit && !oc_f && !sc_f);
    end

    AST_SLEEP_FETS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |-> (chg_fet_n && dsg_fet_n)); // R5
    AST_UV_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACTIVE) && uv_q) |=> (state == ST_SLEEP)); // R5
    AST_OV_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OV_LOCK) && !chg_ok && !uv_q && !slp_q) |=> (state == ST_OV_LOCK)); // R3
    AST_DE_CUTS_DSG: assert property (@(posedge clk) disable iff (!rst_n)
        !de_bit |-> dsg_fet_n); // R7
endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
    import cellguard_pkg::*;
#(
    parameter int OV_DLY  = 4,
    parameter int UV_DLY  = 6,
    parameter int OC_DLY  = 3,
    parameter int SC_DLY  = 1,
    parameter int SLP_DLY = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            ov_cmp,
    input  logic            chg_ok_cmp,
    input  logic            uv_cmp,
    input  logic            oc_cmp,
    input  logic            sc_cmp,
    input  logic            sleep_req,
    input  logic            reg_wr,
    input  logic            reg_addr,
    input  logic [WR_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    output logic            chg_fet_n,
    output logic            dsg_fet_n,
    output logic            recov_en
);
    localparam int LIMS [NUM_COND] = '{OV_DLY, UV_DLY, OC_DLY, SC_DLY, SLP_DLY};

    logic [NUM_COND-1:0] raw;
    logic [NUM_COND-1:0] qual;
    logic ov_f, uv_f, oc_f, sc_f, de_bit, ce_bit, in_sleep, wake_pulse;

    always_comb begin
        raw        = '0;
        raw[C_OV]  = ov_cmp;
        raw[C_UV]  = uv_cmp;
        raw[C_OC]  = oc_cmp;
        raw[C_SC]  = sc_cmp;
        raw[C_SLP] = sleep_req;
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_qual
        cg_qual_timer #(.LIMIT(LIMS[g])) u_tmr (
            .clk (clk),
            .rst_n (rst_n),
            .tick (tick),
            .cond (raw[g]),
            .qual (qual[g])
        );
    end

    cg_regs u_regs (
        .clk (clk), .rst_n (rst_n),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .qual (qual), .oc_raw (oc_cmp), .sc_raw (sc_cmp),
        .wake_pulse (wake_pulse), .in_sleep (in_sleep),
        .ov_f (ov_f), .uv_f (uv_f), .oc_f (oc_f), .sc_f (sc_f),
        .de_bit (de_bit), .ce_bit (ce_bit), .reg_rdata (reg_rdata)
    );

    cg_mode_fsm u_fsm (
        .clk (clk), .rst_n (rst_n),
        .ov_q (qual[C_OV]), .uv_q (qual[C_UV]), .slp_q (qual[C_SLP]),
        .chg_ok (chg_ok_cmp), .uv_raw (uv_cmp), .sleep_req (sleep_req),
        .de_bit (de_bit), .ce_bit (ce_bit), .oc_f (oc_f), .sc_f (sc_f),
        .chg_fet_n (chg_fet_n), .dsg_fet_n (dsg_fet_n), .recov_en (recov_en),
        .in_sleep (in_sleep), .wake_pulse (wake_pulse)
    );

    AST_SC_FASTER: assert property (@(posedge clk) disable iff (!rst_n)
        SC_DLY < OC_DLY); // R9
endmodule

// File: tb/cellguard_ctrl_test.sv
`timescale 1ns/1ps
module cellguard_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ov_cmp = 1'b0, chg_ok_cmp = 1'b0, uv_cmp = 1'b0;
    logic       oc_cmp = 1'b0, sc_cmp = 1'b0, sleep_req = 1'b0;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [4:0] reg_rdata;
    logic       chg_fet_n, dsg_fet_n, recov_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cellguard_ctrl uut (
        .clk (clk), .rst_n (rst_n), .tick (tick),
        .ov_cmp (ov_cmp), .chg_ok_cmp (chg_ok_cmp), .uv_cmp (uv_cmp),
        .oc_cmp (oc_cmp), .sc_cmp (sc_cmp), .sleep_req (sleep_req),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .chg_fet_n (chg_fet_n),
        .dsg_fet_n (dsg_fet_n), .recov_en (recov_en)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic give_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic wr(logic a, logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic a, output logic [4:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic t_reset;
        logic [4:0] v;
        rd(1'b0, v); chk("R1 status", 8'(v), 8'h00);
        rd(1'b1, v); chk("R1 control", 8'(v), 8'h03);
        chk("R1 fets", {6'b0, chg_fet_n, dsg_fet_n}, 8'h0);
        chk("R1/R6 recov", 8'(recov_en), 8'h0);
    endtask

    task automatic t_ov;
        logic [4:0] v;
        ov_cmp = 1'b1;
        give_ticks(3); settle(2);
        chk("R4 ov short no trip", 8'(chg_fet_n), 8'h0);
        give_ticks(1); settle(2);
        chk("R2 chg off", 8'(chg_fet_n), 8'h1);
        chk("R2 dsg on", 8'(dsg_fet_n), 8'h0);
        rd(1'b0, v); chk("R2 ov flag", 8'(v), 8'h01);
        ov_cmp = 1'b0; settle(3);
        chk("R3 chg stays off", 8'(chg_fet_n), 8'h1);
        chg_ok_cmp = 1'b1; settle(2);
        chk("R3 chg resumes", 8'(chg_fet_n), 8'h0);
        chg_ok_cmp = 1'b0;
        wr(1'b0, 4'h0); rd(1'b0, v); chk("R11 write0 keeps ov", 8'(v), 8'h01);
        wr(1'b0, 4'h1); rd(1'b0, v); chk("R11 w1c ov", 8'(v), 8'h00);
    endtask

    task automatic t_enables;
        logic [4:0] v;
        wr(1'b1, 4'h2); settle(1);
        chk("R7 de=0 cuts dsg", 8'(dsg_fet_n), 8'h1);
        chk("R7 chg unaffected", 8'(chg_fet_n), 8'h0);
        wr(1'b1, 4'h1); settle(1);
        chk("R7 ce=0 cuts chg", {6'b0, chg_fet_n, dsg_fet_n}, 8'h2);
        wr(1'b1, 4'h3); settle(1);
        chk("R7 both on", {6'b0, chg_fet_n, dsg_fet_n}, 8'h0);
        rd(1'b1, v); chk("R7 ctrl readback", 8'(v), 8'h03);
    endtask

    task automatic t_sleep_req;
        logic [4:0] v;
        wr(1'b1, 4'h2);
        sleep_req = 1'b1;
        give_ticks(4); settle(2);
        chk("R12 not yet asleep", 8'(recov_en), 8'h0);
        give_ticks(1); settle(2);
        chk("R12/R6 asleep recov", 8'(recov_en), 8'h1);
        chk("R5 fets off in sleep", {6'b0, chg_fet_n, dsg_fet_n}, 8'h3);
        rd(1'b0, v); chk("R5 sleep status bit", 8'(v), 8'h10);
        sleep_req = 1'b0; settle(2);
        chk("R8/R6 awake", 8'(recov_en), 8'h0);
        rd(1'b1, v); chk("R8 de forced on", 8'(v), 8'h03);
        chk("R8 dsg on after wake", 8'(dsg_fet_n), 8'h0);
    endtask

    task automatic t_uv;
        logic [4:0] v;
        uv_cmp = 1'b1;
        give_ticks(6); settle(2);
        chk("R5 uv fets off", {6'b0, chg_fet_n, dsg_fet_n}, 8'h3);
        chk("R5/R6 uv recov", 8'(recov_en), 8'h1);
        rd(1'b0, v); chk("R5 uv flag and sleep", 8'(v), 8'h12);
        uv_cmp = 1'b0; settle(2);
        chk("R8 uv wake", {5'b0, recov_en, chg_fet_n, dsg_fet_n}, 8'h0);
        wr(1'b0, 4'h2); rd(1'b0, v); chk("R11 w1c uv", 8'(v), 8'h00);
    endtask

    task automatic t_oc;
        logic [4:0] v;
        oc_cmp = 1'b1; give_ticks(2); oc_cmp = 1'b0; settle(2);
        oc_cmp = 1'b1; give_ticks(2); settle(2);
        chk("R4 restart no trip", 8'(dsg_fet_n), 8'h0);
        give_ticks(1); settle(2);
        chk("R9 oc dsg off", 8'(dsg_fet_n), 8'h1);
        chk("R9 oc chg on", 8'(chg_fet_n), 8'h0);
        wr(1'b0, 4'h4); rd(1'b0, v);
        chk("R10 w1c with oc present", 8'(v), 8'h04);
        oc_cmp = 1'b0; settle(3);
        chk("R10 latched after clear", 8'(dsg_fet_n), 8'h1);
        wr(1'b0, 4'h4); rd(1'b0, v);
        chk("R10 cleared", 8'(v), 8'h00);
        chk("R10 dsg restored", 8'(dsg_fet_n), 8'h0);
    endtask

    task automatic t_sc;
        logic [4:0] v;
        sc_cmp = 1'b1; settle(4);
        chk("R9 sc needs tick", 8'(dsg_fet_n), 8'h0);
        give_ticks(1); settle(2);
        chk("R9 sc dsg off", 8'(dsg_fet_n), 8'h1);
        rd(1'b0, v); chk("R9 sc flag", 8'(v), 8'h08);
        sc_cmp = 1'b0;
        wr(1'b0, 4'h8); rd(1'b0, v); chk("R10 sc cleared", 8'(v), 8'h00);
    endtask

    initial begin
        fork
            begin
                settle(3);
                rst_n = 1'b1;
                settle(2);
                t_reset;
                t_ov;
                t_enables;
                t_sleep_req;
                t_uv;
                t_oc;
                t_sc;
                done = 1'b1;
            end
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule